// File: doc/BRIEF.md
# Multi-Policy Float-to-Integer Converter

This block turns one binary floating-point operand into a 32-bit or 64-bit integer. The operand is either single or double precision. The integer is either signed or unsigned. A three-bit mode field picks two things: the rounding source, and the policy applied to NaN and to values the destination cannot hold. The rounding source is either a supplied dynamic rounding mode or forced truncation.

There are three policies:
- Platform saturation clamps out-of-range values and sends NaN to the type minimum.
- Language saturation clamps the same way but sends NaN to zero.
- Modular wraparound keeps the exact low bits of the rounded integer and sends NaN and both infinities to zero.

An instruction pipeline issues one conversion per strobe. The result is registered and appears one clock later.

Top module: `fcvt_multi`

## Requirements
- R1: `in_mode[2:1]` selects the policy: 00 platform, 01 language saturation, 10 modular. Codes 110 and 111 raise `out_illegal` and force the result to zero. For legal codes, `in_mode[0]`=1 forces truncation, and `in_mode[0]`=0 uses `in_rm`.
- R2: `in_rm` selects the dynamic rounding of fractional values: 00 nearest-even (2.5 gives 2, -2.5 gives -2), 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: Under the platform policy, NaN yields the destination minimum: -2^(N-1) when signed, 0 when unsigned.
- R4: Under both saturating policies, a rounded value above the destination maximum yields the maximum, and one below the minimum yields the minimum. Infinities saturate by their sign. Any negative value converted to an unsigned destination yields 0. The maximum is 2^N-1 unsigned and 2^(N-1)-1 signed.
- R5: Under the language policy, NaN yields 0, and all other inputs behave as under the platform policy.
- R6: Under the modular policy, NaN and both infinities yield 0.
- R7: Under the modular policy, the result is the rounded integer reduced modulo 2^N, with negatives in two's complement. This stays exact for any exponent, so the result is 0 once the weight of the operand's least significant significand bit is at least 2^N.
- R8: With `in_is_single`=1, the operand is the single-precision value in `in_bits[31:0]` and `in_bits[63:32]` has no effect. With `in_is_single`=0, all 64 bits form a double.
- R9: With `in_wide`=0 (N=32), the result sits in bits [31:0]. Bits [63:32] copy bit 31 for a signed destination and are zero for an unsigned one. With `in_wide`=1, N=64.
- R10: A strobe on `in_valid` produces `out_valid`, `out_result` and `out_illegal` exactly one clock later. Without a strobe, `out_valid` is low and the result and flag hold. Reset clears all outputs.
- R11: Zeros and subnormals convert correctly. They give 0, except that directed rounding away from zero gives +1 (or -1 when signed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion strobe |
| in_bits | input | 64 | Float operand bits (single uses [31:0]) |
| in_is_single | input | 1 | 1: single-precision source, 0: double |
| in_wide | input | 1 | 1: 64-bit destination, 0: 32-bit |
| in_signed | input | 1 | 1: signed destination |
| in_mode | input | 3 | Rounding source and out-of-range policy |
| in_rm | input | 2 | Dynamic rounding mode |
| out_result | output | 64 | Registered integer result |
| out_illegal | output | 1 | Registered illegal-mode flag |
| out_valid | output | 1 | Result valid, one cycle after the strobe |

## Verification
The properties recognise NaN and infinity from the operand's exponent and fraction fields. They read the source sign from bit 31 or bit 63 according to `in_is_single`. They therefore assume the upper half of `in_bits` is irrelevant in single mode, which is itself a requirement.

The sweep drives every mode code (including both illegal codes), every rounding mode and all four destination shapes against each operand. Single-precision operands carry deliberately nonzero upper halves.

The sweep holds the strobe high, so each vector is captured and compared one cycle later. One directed gap exercises the hold behaviour.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int XLEN      = 64;
    localparam int NARROW    = 32;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
    localparam int SIG_W     = DP_FRAC_W + 1;
    localparam int EXP_W     = DP_EXP_W + 2;
    localparam int SHR_MAX   = SIG_W + 2;
    localparam int SHC_W     = $clog2(SHR_MAX + 1);
    localparam int LSH_W     = $clog2(XLEN);

    typedef enum logic [1:0] {
        RM_RNE = 2'b00,
        RM_RTZ = 2'b01,
        RM_RUP = 2'b10,
        RM_RDN = 2'b11
    } rm_e;

    typedef enum logic [1:0] {
        POL_PLAT = 2'b00,
        POL_LANG = 2'b01,
        POL_MOD  = 2'b10,
        POL_BAD  = 2'b11
    } pol_e;

    typedef struct packed {
        logic                    sign;
        logic                    is_nan;
        logic                    is_inf;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
    } operand_t;

    typedef struct packed {
        logic            huge;
        logic [XLEN-1:0] mag;
    } magnitude_t;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] result;
    } out_state_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [XLEN-1:0] bits_i,
    input  logic            single_i,
    output operand_t        op_o
);
    logic [DP_EXP_W-1:0]  dexp;
    logic [DP_FRAC_W-1:0] dfrac;
    logic [SP_EXP_W-1:0]  sexp;
    logic [SP_FRAC_W-1:0] sfrac;

    assign dexp  = bits_i[DP_FRAC_W +: DP_EXP_W];
    assign dfrac = bits_i[DP_FRAC_W-1:0];
    assign sexp  = bits_i[SP_FRAC_W +: SP_EXP_W];
    assign sfrac = bits_i[SP_FRAC_W-1:0];

    // Common form: value = sig * 2^(exp - DP_FRAC_W), sig left-aligned to 53 bits
    always_comb begin
        int e_raw;
        op_o = '0;
        if (single_i) begin
            e_raw       = (sexp == '0) ? 1 : int'(sexp);
            op_o.sign   = bits_i[SP_FRAC_W + SP_EXP_W];
            op_o.is_nan = (sexp == '1) && (sfrac != '0);
            op_o.is_inf = (sexp == '1) && (sfrac == '0);
            op_o.exp    = EXP_W'(e_raw - SP_BIAS);
            op_o.sig    = {(sexp != '0), sfrac, {(DP_FRAC_W - SP_FRAC_W){1'b0}}};
        end else begin
            e_raw       = (dexp == '0) ? 1 : int'(dexp);
            op_o.sign   = bits_i[DP_FRAC_W + DP_EXP_W];
            op_o.is_nan = (dexp == '1) && (dfrac != '0);
            op_o.is_inf = (dexp == '1) && (dfrac == '0);
            op_o.exp    = EXP_W'(e_raw - DP_BIAS);
            op_o.sig    = {(dexp != '0), dfrac};
        end
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0]        sig_i,
    input  rm_e                     rm_i,
    output magnitude_t              mag_o
);
    logic [SIG_W+XLEN-1:0] shifted;
    logic [SIG_W-1:0]      int_part;
    logic [XLEN-1:0]       ext_sig;
    logic [SHC_W-1:0]      shc;
    logic [LSH_W-1:0]      lsh;
    logic                  rnd_bit;
    logic                  sticky;
    logic                  inc;

    assign ext_sig = {{(XLEN - SIG_W){1'b0}}, sig_i};

    always_comb begin
        int sh;
        sh       = DP_FRAC_W - int'(exp_i);
        shifted  = '0;
        int_part = '0;
        shc      = '0;
        lsh      = '0;
        rnd_bit  = 1'b0;
        sticky   = 1'b0;
        inc      = 1'b0;
        mag_o    = '0;
        // At or above 2^XLEN the magnitude cannot fit; low bits stay exact
        mag_o.huge = int'(exp_i) >= XLEN;
        if (sh <= 0) begin
            if (-sh < XLEN) begin
                lsh       = LSH_W'(-sh);
                mag_o.mag = ext_sig << lsh;
            end
        end else begin
            shc      = (sh > SHR_MAX) ? SHC_W'(SHR_MAX) : SHC_W'(sh);
            shifted  = {sig_i, {XLEN{1'b0}}} >> shc;
            int_part = shifted[XLEN +: SIG_W];
            rnd_bit  = shifted[XLEN-1];
            sticky   = |shifted[XLEN-2:0];
            case (rm_i)
                RM_RNE:  inc = rnd_bit & (sticky | int_part[0]);
                RM_RTZ:  inc = 1'b0;
                RM_RUP:  inc = ~sign_i & (rnd_bit | sticky);
                default: inc = sign_i & (rnd_bit | sticky);
            endcase
            mag_o.mag = XLEN'(int_part) + XLEN'(inc);
        end
    end
endmodule

// File: rtl/fcvt_policy.sv
module fcvt_policy
    import fcvt_pkg::*;
(
    input  logic            sign_i,
    input  logic            is_nan_i,
    input  logic            is_inf_i,
    input  magnitude_t      mag_i,
    input  pol_e            pol_i,
    input  logic            wide_i,
    input  logic            signed_i,
    output logic [XLEN-1:0] result_o
);
    logic [XLEN-1:0] umax;
    logic [XLEN-1:0] smax;
    logic [XLEN-1:0] smin_mag;
    logic [XLEN-1:0] smin_val;
    logic [XLEN-1:0] twos;
    logic [XLEN-1:0] raw;
    logic            u_over;
    logic            sp_over;
    logic            sn_over;

    always_comb begin
        umax     = wide_i ? '1 : XLEN'({NARROW{1'b1}});
        smax     = umax >> 1;
        smin_mag = smax + XLEN'(1);
        smin_val = ~smax;
        twos     = sign_i ? (~mag_i.mag + XLEN'(1)) : mag_i.mag;
        u_over   = mag_i.huge || (mag_i.mag > umax);
        sp_over  = mag_i.huge || (mag_i.mag > smax);
        sn_over  = mag_i.huge || (mag_i.mag > smin_mag);
        raw      = '0;
        case (pol_i)
            POL_PLAT, POL_LANG: begin
                if (is_nan_i) begin
                    raw = (pol_i == POL_PLAT && signed_i) ? smin_val : '0;
                end else if (!signed_i) begin
                    raw = sign_i ? '0 : (u_over ? umax : mag_i.mag);
                end else if (sign_i) begin
                    raw = sn_over ? smin_val : twos;
                end else begin
                    raw = sp_over ? smax : twos;
                end
            end
            POL_MOD: raw = (is_nan_i || is_inf_i) ? '0 : twos;
            default: raw = '0;
        endcase
        if (wide_i) begin
            result_o = raw;
        end else if (signed_i) begin
            result_o = {{(XLEN - NARROW){raw[NARROW-1]}}, raw[NARROW-1:0]};
        end else begin
            result_o = {{(XLEN - NARROW){1'b0}}, raw[NARROW-1:0]};
        end
    end
endmodule

// File: rtl/fcvt_multi.sv
module fcvt_multi
    import fcvt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_bits,
    input  logic            in_is_single,
    input  logic            in_wide,
    input  logic            in_signed,
    input  logic [2:0]      in_mode,
    input  logic [1:0]      in_rm,
    output logic [XLEN-1:0] out_result,
    output logic            out_illegal,
    output logic            out_valid
);
    operand_t        op;
    magnitude_t      mag;
    pol_e            pol;
    rm_e             eff_rm;
    logic [XLEN-1:0] conv;
    out_state_t      st_d;
    out_state_t      st_q;

    // Upper mode bits pick the policy, bit 0 forces truncation
    assign pol    = pol_e'(in_mode[2:1]);
    assign eff_rm = in_mode[0] ? RM_RTZ : rm_e'(in_rm);

    fcvt_unpack u_unpack (
        .bits_i   (in_bits),
        .single_i (in_is_single),
        .op_o     (op)
    );

    fcvt_align u_align (
        .sign_i (op.sign),
        .exp_i  (op.exp),
        .sig_i  (op.sig),
        .rm_i   (eff_rm),
        .mag_o  (mag)
    );

    fcvt_policy u_policy (
        .sign_i   (op.sign),
        .is_nan_i (op.is_nan),
        .is_inf_i (op.is_inf),
        .mag_i    (mag),
        .pol_i    (pol),
        .wide_i   (in_wide),
        .signed_i (in_signed),
        .result_o (conv)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = (pol == POL_BAD);
            st_d.result  = (pol == POL_BAD) ? '0 : conv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_result  = st_q.result;
    assign out_illegal = st_q.illegal;
    assign out_valid   = st_q.valid;
endmodule

// File: rtl/fcvt_multi_chk.sv
module fcvt_multi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_bits,
    input logic        in_is_single,
    input logic        in_wide,
    input logic        in_signed,
    input logic [2:0]  in_mode,
    input logic [63:0] out_result,
    input logic        out_illegal,
    input logic        out_valid
);
    logic src_sign;
    logic src_nan;
    logic src_inf;

    assign src_sign = in_is_single ? in_bits[31] : in_bits[63];
    assign src_nan  = in_is_single ? (in_bits[30:23] == 8'hFF && in_bits[22:0] != 0)
                                   : (in_bits[62:52] == 11'h7FF && in_bits[51:0] != 0);
    assign src_inf  = in_is_single ? (in_bits[30:23] == 8'hFF && in_bits[22:0] == 0)
                                   : (in_bits[62:52] == 11'h7FF && in_bits[51:0] == 0);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal))); // R10
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_illegal == ($past(in_mode[2:1]) == 2'b11))); // R1
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == 64'd0)); // R1
    AST_PLAT_NAN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[2:1] == 2'b00 && src_nan && !in_wide && in_signed)
        |=> (out_result == 64'hFFFF_FFFF_8000_0000)); // R3
    AST_UNSIGNED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode[2] && !in_signed && src_sign) |=> (out_result == 64'd0)); // R4
    AST_LANG_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[2:1] == 2'b01 && src_nan) |=> (out_result == 64'd0)); // R5
    AST_MOD_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[2:1] == 2'b10 && (src_nan || src_inf)) |=> (out_result == 64'd0)); // R6
    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && !in_signed) |=> (out_result[63:32] == 32'd0)); // R9
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && in_signed) |=> (out_result[63:32] == {32{out_result[31]}})); // R9
endmodule

bind fcvt_multi fcvt_multi_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_bits      (in_bits),
    .in_is_single (in_is_single),
    .in_wide      (in_wide),
    .in_signed    (in_signed),
    .in_mode      (in_mode),
    .out_result   (out_result),
    .out_illegal  (out_illegal),
    .out_valid    (out_valid)
);

// File: tb/sim_fcvt_multi.sv
module sim_fcvt_multi;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_bits;
    logic        in_is_single;
    logic        in_wide;
    logic        in_signed;
    logic [2:0]  in_mode;
    logic [1:0]  in_rm;
    logic [63:0] out_result;
    logic        out_illegal;
    logic        out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] dvec[$];
    logic [31:0] svec[$];

    always #5 clk = ~clk;

    fcvt_multi u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_bits      (in_bits),
        .in_is_single (in_is_single),
        .in_wide      (in_wide),
        .in_signed    (in_signed),
        .in_mode      (in_mode),
        .in_rm        (in_rm),
        .out_result   (out_result),
        .out_illegal  (out_illegal),
        .out_valid    (out_valid)
    );

    localparam real P32 = 4294967296.0;

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic chk(string tag, string what, logic [65:0] act, logic [65:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic real sp_value(logic [31:0] b);
        int  e;
        real fr;
        real m;
        e  = int'(b[30:23]);
        fr = real'(int'(b[22:0]));
        if (e == 0) m = fr * (2.0 ** (-149));
        else        m = (fr + 8388608.0) * (2.0 ** (e - 150));
        return b[31] ? -m : m;
    endfunction

    function automatic real rint(real v, int rm);
        real f;
        real d;
        f = $floor(v);
        d = v - f;
        case (rm)
            0: begin
                if (d > 0.5) return f + 1.0;
                if (d < 0.5) return f;
                return ((f - 2.0 * $floor(f / 2.0)) == 0.0) ? f : f + 1.0;
            end
            1: return (v >= 0.0) ? f : $ceil(v);
            2: return $ceil(v);
            default: return f;
        endcase
    endfunction

    // Exact low 64 bits of a non-negative integer-valued real
    function automatic logic [63:0] low64(real a);
        real hi;
        real lo;
        real hl;
        hi = $floor(a / P32);
        lo = a - hi * P32;
        hl = hi - $floor(hi / P32) * P32;
        return {32'(longint'(hl)), 32'(longint'(lo))};
    endfunction

    function automatic logic [63:0] wrap(real r);
        logic [63:0] m;
        m = low64((r < 0.0) ? -r : r);
        return (r < 0.0) ? -m : m;
    endfunction

    function automatic logic [64:0] model(logic [63:0] bits, bit single, bit wide, bit sgn,
                                          logic [2:0] mode, logic [1:0] rm, output string tag);
        int          n;
        int          pol;
        int          erm;
        bit          nan;
        bit          inf;
        bit          neg;
        real         v;
        real         r;
        logic [63:0] umax;
        logic [63:0] smax;
        logic [63:0] smin;
        logic [63:0] res;
        n    = wide ? 64 : 32;
        pol  = int'(mode[2:1]);
        erm  = mode[0] ? 1 : int'(rm);
        umax = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        smax = (64'd1 << (n - 1)) - 64'd1;
        smin = -(64'd1 << (n - 1));
        if (pol == 3) begin
            tag = "R1";
            return 65'd1 << 64;
        end
        if (single) begin
            nan = bits[30:23] == 8'hFF && bits[22:0] != 0;
            inf = bits[30:23] == 8'hFF && bits[22:0] == 0;
            neg = bits[31];
        end else begin
            nan = bits[62:52] == 11'h7FF && bits[51:0] != 0;
            inf = bits[62:52] == 11'h7FF && bits[51:0] == 0;
            neg = bits[63];
        end
        if (nan) begin
            tag = (pol == 0) ? "R3" : (pol == 1) ? "R5" : "R6";
            res = (pol == 0 && sgn) ? smin : 64'd0;
        end else if (inf) begin
            tag = (pol == 2) ? "R6" : "R4";
            if (pol == 2)  res = 64'd0;
            else if (neg)  res = sgn ? smin : 64'd0;
            else           res = sgn ? smax : umax;
        end else begin
            v = single ? sp_value(bits[31:0]) : $bitstoreal(bits);
            r = rint(v, erm);
            if (pol == 2)                          tag = "R7";
            else if (v < 1.0 && v > -1.0)          tag = "R11";
            else if (single)                       tag = "R8";
            else if (!wide)                        tag = "R9";
            else if (r != v)                       tag = "R2";
            else                                   tag = "R4";
            if (pol == 2) begin
                res = wrap(r);
            end else if (!sgn) begin
                if (r < 0.0)                   res = 64'd0;
                else if (r >= 2.0 ** n)        res = umax;
                else                           res = low64(r);
            end else begin
                if (r >= 2.0 ** (n - 1))       res = smax;
                else if (r < -(2.0 ** (n - 1))) res = smin;
                else                           res = wrap(r);
            end
        end
        if (!wide) res = sgn ? {{32{res[31]}}, res[31:0]} : {32'd0, res[31:0]};
        return {1'b0, res};
    endfunction

    task automatic sweep(logic [63:0] bits, bit single);
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 4; r++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int s = 0; s < 2; s++) begin
                        string       tag;
                        logic [64:0] exp;
                        @(negedge clk);
                        in_valid     = 1'b1;
                        in_bits      = bits;
                        in_is_single = single;
                        in_wide      = w[0];
                        in_signed    = s[0];
                        in_mode      = m[2:0];
                        in_rm        = r[1:0];
                        exp = model(bits, single, w[0], s[0], m[2:0], r[1:0], tag);
                        @(negedge clk);
                        chk(tag, $sformatf("bits=%h sp=%0d mode=%0d rm=%0d wide=%0d sgn=%0d",
                                           bits, single, m, r, w, s),
                            {out_valid, out_illegal, out_result}, {1'b1, exp});
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        in_valid     = 1'b0;
        in_bits      = '0;
        in_is_single = 1'b0;
        in_wide      = 1'b0;
        in_signed    = 1'b0;
        in_mode      = '0;
        in_rm        = '0;
        repeat (3) @(negedge clk);
        chk("R10", "reset state", {out_valid, out_illegal, out_result}, 66'd0);
        rst_n = 1'b1;

        dvec.push_back(64'h0000_0000_0000_0000);
        dvec.push_back(64'h8000_0000_0000_0000);
        dvec.push_back($realtobits(0.5));
        dvec.push_back($realtobits(-0.5));
        dvec.push_back($realtobits(1.5));
        dvec.push_back($realtobits(-1.5));
        dvec.push_back($realtobits(2.5));
        dvec.push_back($realtobits(-2.5));
        dvec.push_back($realtobits(3.7));
        dvec.push_back($realtobits(-3.7));
        dvec.push_back($realtobits(12345.678));
        dvec.push_back($realtobits(-98765.4321));
        dvec.push_back($realtobits(2147483647.0));
        dvec.push_back($realtobits(2147483647.5));
        dvec.push_back($realtobits(2147483648.0));
        dvec.push_back($realtobits(-2147483648.0));
        dvec.push_back($realtobits(-2147483648.5));
        dvec.push_back($realtobits(-2147483649.0));
        dvec.push_back($realtobits(4294967295.0));
        dvec.push_back($realtobits(4294967295.5));
        dvec.push_back($realtobits(4294967296.0));
        dvec.push_back($realtobits(2.0 ** 63));
        dvec.push_back($realtobits(-(2.0 ** 63)));
        dvec.push_back($realtobits(2.0 ** 63 - 1024.0));
        dvec.push_back($realtobits(2.0 ** 64));
        dvec.push_back($realtobits(-(2.0 ** 64)));
        dvec.push_back($realtobits(2.0 ** 80 + 2.0 ** 30));
        dvec.push_back($realtobits(-(2.0 ** 70 + 3.0 * 2.0 ** 20)));
        dvec.push_back($realtobits(2.0 ** 100));
        dvec.push_back($realtobits(2.0 ** 52 + 1.0));
        dvec.push_back($realtobits(-(2.0 ** 52) - 3.0));
        dvec.push_back($realtobits(1.0e300));
        dvec.push_back($realtobits(-1.0e300));
        dvec.push_back(64'h7FF8_0000_0000_0000);
        dvec.push_back(64'hFFF8_0000_0000_0001);
        dvec.push_back(64'h7FF0_0000_0000_0000);
        dvec.push_back(64'hFFF0_0000_0000_0000);
        dvec.push_back(64'h0000_0000_0000_0001);
        dvec.push_back(64'h8000_0000_0000_0001);

        svec.push_back(32'h0000_0000);
        svec.push_back(32'h8000_0000);
        svec.push_back(32'h3F00_0000);
        svec.push_back(32'hBF00_0000);
        svec.push_back(32'h3FC0_0000);
        svec.push_back(32'h4020_0000);
        svec.push_back(32'hC020_0000);
        svec.push_back(32'hC070_0000);
        svec.push_back(32'h4B00_0001);
        svec.push_back(32'h4F00_0000);
        svec.push_back(32'hCF00_0000);
        svec.push_back(32'h4F7F_FFFF);
        svec.push_back(32'h4F80_0000);
        svec.push_back(32'h5F00_0000);
        svec.push_back(32'hDF00_0000);
        svec.push_back(32'h5F80_0000);
        svec.push_back(32'h6F80_0001);
        svec.push_back(32'h7F7F_FFFF);
        svec.push_back(32'h7FC0_0000);
        svec.push_back(32'h7F80_0000);
        svec.push_back(32'hFF80_0000);
        svec.push_back(32'h0000_0001);
        svec.push_back(32'h8000_0001);

        foreach (dvec[i]) sweep(dvec[i], 1'b0);
        // R8: upper half carries junk that must not matter
        foreach (svec[i]) sweep({~svec[i] ^ 32'h5A5A_A5A5, svec[i]}, 1'b1);

        // R10: a gap without strobe holds the last result
        @(negedge clk);
        in_valid     = 1'b1;
        in_bits      = $realtobits(-7.0);
        in_is_single = 1'b0;
        in_wide      = 1'b1;
        in_signed    = 1'b1;
        in_mode      = 3'b001;
        @(negedge clk);
        chk("R10", "strobe result", {out_valid, out_illegal, out_result},
            {2'b10, 64'hFFFF_FFFF_FFFF_FFF9});
        in_valid = 1'b0;
        in_bits  = $realtobits(99.0);
        in_mode  = 3'b110;
        @(negedge clk);
        chk("R10", "hold without strobe", {out_valid, out_illegal, out_result},
            {2'b00, 64'hFFFF_FFFF_FFFF_FFF9});

        summary();
        $finish;
    end
endmodule